// File: doc/BRIEF.md
# Serial ADC Conversion and Calibration Sequencer

This block is the host-side controller for an externally clocked 16-bit successive-approximation converter with a serial result port. When a conversion is requested, it raises the converter's sample strobe for a programmed acquisition window. After a first-clock delay it drives a burst of converter clock pulses. The converter answers with a serial clock and data pair. The controller synchronises that pair into the system clock domain, shifts the bits in MSB first, and presents the finished word with a one-cycle valid strobe once the converter drops its busy line.

A calibration request drives a separate sequence. The controller raises the calibration strobe for a fixed width. It then supplies free-running converter clocks until the converter reports the end of calibration by dropping busy. All widths are counts of system clock cycles set through parameters. A watchdog bounds every wait on busy, so a stuck converter cannot hang the host.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, ready is 1, result_valid is 0, timeout_err is 0, result_data is 0, and adc_sample, adc_clk and adc_cal are all 0.
- R2: An accepted conversion request holds adc_sample high for exactly SAMPLE_CYC cycles. The first adc_clk rise follows the fall of adc_sample by exactly FIRST_DLY_CYC cycles.
- R3: A conversion issues exactly RES_BITS+1 (17) adc_clk pulses. Each pulse is high for CLK_HI_CYC cycles, and consecutive rises are CLK_HI_CYC+CLK_LO_CYC cycles apart.
- R4: Data is taken from adc_sdata on each rising edge of adc_sclk, MSB first, with the first bit landing in result_data[15]. result_data is updated and result_valid is high for one cycle only after 16 bits are held and busy is low.
- R5: ready is 0 from an accepted request until the controller is back in idle. A request while ready is 0 is ignored, and this includes a request while adc_busy is high in idle.
- R6: When conv_req and cal_req arrive in the same cycle, calibration is started and the conversion request is dropped.
- R7: Calibration holds adc_cal high for exactly CAL_PULSE_CYC cycles. It then issues adc_clk pulses until adc_busy has been seen high and then low. It returns to idle without a result_valid strobe.
- R8: If busy does not complete within WAIT_LIMIT_CYC cycles of entering a wait, the controller returns to idle and sets timeout_err. For calibration this is WAIT_LIMIT_CYC cycles after adc_cal falls. The next accepted request clears timeout_err.
- R9: adc_sample, adc_clk and adc_cal are never high together in any pair, and all three are low whenever ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_req | input | 1 | Request one conversion |
| cal_req | input | 1 | Request a calibration cycle |
| ready | output | 1 | Idle and converter not busy; requests accepted |
| result_data | output | 16 | Last converted word |
| result_valid | output | 1 | One-cycle strobe when result_data is updated |
| timeout_err | output | 1 | Busy wait exceeded the bound |
| adc_sample | output | 1 | Sample strobe to converter |
| adc_clk | output | 1 | Converter clock |
| adc_cal | output | 1 | Calibration strobe to converter |
| adc_busy | input | 1 | Converter busy (asynchronous) |
| adc_sclk | input | 1 | Converter serial clock (asynchronous) |
| adc_sdata | input | 1 | Converter serial data (asynchronous) |

## Verification
A wrong sequencer state shows at the converter pins within one pulse period. It appears as a sample window or first-clock gap of the wrong length, a 16th or 18th clock pulse, or a stray calibration strobe. A capture fault shows as a wrong bit in result_data on the very conversion where it occurs. The bench sweeps walking-one and mixed patterns so that every bit position and shift order is exposed. A watchdog fault shows as a timeout_err and a return to ready that come too early or too late, measured to the exact cycle from the fall of the calibration strobe.

// File: rtl/adc_seq_pkg.sv
// Shared types for the converter sequencer.
// Assumes: a single system clock domain for all sequencing logic.
package adc_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAMP,
        ST_FCD,
        ST_CLK,
        ST_CWAIT,
        ST_CALP,
        ST_CALRUN
    } seq_state_t;
endpackage

// File: rtl/adc_clk_gen.sv
// Converter clock generator: while en is high, produces a square wave whose
// first system cycle is high. Each period is HI cycles high, then LO cycles low.
// Assumes en is held for whole periods by the caller; dropping en forces low.
module adc_clk_gen #(
    parameter int HI = 29,
    parameter int LO = 29
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic clk_out,
    output logic period_end
);
    localparam int PER = HI + LO;
    localparam int CW  = $clog2(PER);

    logic [CW-1:0] phase;

    // Phase counter across one converter clock period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) phase <= '0;
        else if (phase == CW'(PER - 1)) phase <= '0;
        else phase <= phase + 1'b1;
    end

    assign clk_out    = en && (phase < CW'(HI));
    assign period_end = en && (phase == CW'(PER - 1));

    generate
        if (HI >= 2) begin : g_hi_chk
            // R3: a high phase lasts more than one cycle while enabled.
            a_r3_high_holds: assert property (@(posedge clk) disable iff (!rst_n)
                ($rose(clk_out) && en) |=> (clk_out || !en));
        end
    endgenerate
endmodule

// File: rtl/adc_bit_capture.sv
// Serial capture: two-stage synchronises busy, sclk and sdata. On each
// synchronised sclk rise it shifts sdata in MSB first, up to NBITS bits.
// Assumes sclk high and low phases each last at least two system cycles.
module adc_bit_capture #(
    parameter int NBITS = 16,
    localparam int CNT_W = $clog2(NBITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             busy_in,
    input  logic             sclk_in,
    input  logic             sdata_in,
    output logic             busy_s,
    output logic [NBITS-1:0] word,
    output logic [CNT_W-1:0] bit_cnt
);
    logic [1:0] busy_q, sclk_q, sdata_q;
    logic       sclk_prev;
    logic       sclk_rise;

    // Two-flop synchronisers and edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= '0;
            sclk_q    <= '0;
            sdata_q   <= '0;
            sclk_prev <= 1'b0;
        end else begin
            busy_q    <= {busy_q[0], busy_in};
            sclk_q    <= {sclk_q[0], sclk_in};
            sdata_q   <= {sdata_q[0], sdata_in};
            sclk_prev <= sclk_q[1];
        end
    end

    assign busy_s    = busy_q[1];
    assign sclk_rise = sclk_q[1] && !sclk_prev;

    // Shift register and bit count, saturating at NBITS.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            word    <= '0;
            bit_cnt <= '0;
        end else if (sclk_rise && (bit_cnt < CNT_W'(NBITS))) begin
            word    <= {word[NBITS-2:0], sdata_q[1]};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // R4: a full word is frozen until the next clear.
    a_r4_full_word_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt == CNT_W'(NBITS) && !clear) |=> $stable(word));
endmodule

// File: rtl/adc_busy_watchdog.sv
// Busy watchdog: counts cycles while armed. It flags expiry on the LIMIT-th
// armed cycle. Disarming clears the count.
// Assumes LIMIT >= 2.
module adc_busy_watchdog #(
    parameter int LIMIT = 6_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Armed-cycle counter, saturating at LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm) cnt <= '0;
        else if (cnt != CW'(LIMIT)) cnt <= cnt + 1'b1;
    end

    assign expired = arm && (cnt == CW'(LIMIT - 1));

    // R8: expiry never coincides with the first armed cycle.
    a_r8_no_early_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arm) |-> !expired);
endmodule

// File: rtl/adc_seq_ctrl.sv
// Top sequencer for a serial-output SAR converter. It runs conversion
// (sample window, first-clock delay, RES_BITS+1 clock pulses, wait for busy)
// and calibration (strobe, then clocks until busy completes), each bounded
// by a watchdog.
// Assumes every *_CYC parameter is at least 1, and CLK_HI_CYC and CLK_LO_CYC
// are at least 3.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_BITS       = 16,
    parameter int CLK_HI_CYC     = 29,
    parameter int CLK_LO_CYC     = 29,
    parameter int SAMPLE_CYC     = 210,
    parameter int FIRST_DLY_CYC  = 5,
    parameter int CAL_PULSE_CYC  = 10,
    parameter int WAIT_LIMIT_CYC = 6_000_000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                conv_req,
    input  logic                cal_req,
    output logic                ready,
    output logic [RES_BITS-1:0] result_data,
    output logic                result_valid,
    output logic                timeout_err,
    output logic                adc_sample,
    output logic                adc_clk,
    output logic                adc_cal,
    input  logic                adc_busy,
    input  logic                adc_sclk,
    input  logic                adc_sdata
);
    localparam int NPULSE  = RES_BITS + 1;
    localparam int TMR_A   = (SAMPLE_CYC > FIRST_DLY_CYC) ? SAMPLE_CYC : FIRST_DLY_CYC;
    localparam int TMR_MAX = (TMR_A > CAL_PULSE_CYC) ? TMR_A : CAL_PULSE_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int PC_W    = $clog2(NPULSE + 1);
    localparam int BC_W    = $clog2(RES_BITS + 1);

    seq_state_t          state;
    logic [TMR_W-1:0]    tmr;
    logic [PC_W-1:0]     pulses;
    logic                seen_busy;
    logic                busy_s;
    logic [RES_BITS-1:0] cap_word;
    logic [BC_W-1:0]     cap_cnt;
    logic                gen_en, period_end, wd_arm, wd_expired;

    assign gen_en = (state == ST_CLK) || (state == ST_CALRUN);
    assign wd_arm = (state == ST_CWAIT) || (state == ST_CALRUN);

    adc_clk_gen #(.HI(CLK_HI_CYC), .LO(CLK_LO_CYC)) clkgen_i (
        .clk(clk), .rst_n(rst_n), .en(gen_en),
        .clk_out(adc_clk), .period_end(period_end)
    );

    adc_bit_capture #(.NBITS(RES_BITS)) cap_i (
        .clk(clk), .rst_n(rst_n), .clear(state == ST_SAMP),
        .busy_in(adc_busy), .sclk_in(adc_sclk), .sdata_in(adc_sdata),
        .busy_s(busy_s), .word(cap_word), .bit_cnt(cap_cnt)
    );

    adc_busy_watchdog #(.LIMIT(WAIT_LIMIT_CYC)) wd_i (
        .clk(clk), .rst_n(rst_n), .arm(wd_arm), .expired(wd_expired)
    );

    // Sequencer: steps conversion and calibration phases and registers results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            tmr          <= '0;
            pulses       <= '0;
            seen_busy    <= 1'b0;
            result_data  <= '0;
            result_valid <= 1'b0;
            timeout_err  <= 1'b0;
        end else begin
            result_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    tmr <= '0;
                    if (!busy_s && cal_req) begin
                        state       <= ST_CALP;
                        timeout_err <= 1'b0;
                    end else if (!busy_s && conv_req) begin
                        state       <= ST_SAMP;
                        timeout_err <= 1'b0;
                    end
                end
                ST_SAMP: begin
                    if (tmr == TMR_W'(SAMPLE_CYC - 1)) begin
                        state <= ST_FCD;
                        tmr   <= '0;
                    end else tmr <= tmr + 1'b1;
                end
                ST_FCD: begin
                    if (tmr == TMR_W'(FIRST_DLY_CYC - 1)) begin
                        state  <= ST_CLK;
                        tmr    <= '0;
                        pulses <= '0;
                    end else tmr <= tmr + 1'b1;
                end
                ST_CLK: begin
                    if (period_end) begin
                        if (pulses == PC_W'(NPULSE - 1)) state <= ST_CWAIT;
                        else pulses <= pulses + 1'b1;
                    end
                end
                ST_CWAIT: begin
                    if (wd_expired) begin
                        state       <= ST_IDLE;
                        timeout_err <= 1'b1;
                    end else if (!busy_s && cap_cnt == BC_W'(RES_BITS)) begin
                        state        <= ST_IDLE;
                        result_data  <= cap_word;
                        result_valid <= 1'b1;
                    end
                end
                ST_CALP: begin
                    if (tmr == TMR_W'(CAL_PULSE_CYC - 1)) begin
                        state     <= ST_CALRUN;
                        tmr       <= '0;
                        seen_busy <= 1'b0;
                    end else tmr <= tmr + 1'b1;
                end
                ST_CALRUN: begin
                    if (wd_expired) begin
                        state       <= ST_IDLE;
                        timeout_err <= 1'b1;
                    end else if (busy_s) seen_busy <= 1'b1;
                    else if (seen_busy) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ready      = (state == ST_IDLE) && !busy_s;
    assign adc_sample = (state == ST_SAMP);
    assign adc_cal    = (state == ST_CALP);

    // R9: converter strobes are mutually exclusive.
    a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({adc_sample, adc_clk, adc_cal}));
    // R9: nothing is driven high while ready.
    a_r9_quiet_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !(adc_sample || adc_clk || adc_cal));
    // R4: the valid strobe lasts one cycle.
    a_r4_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);
    // R5: sampling starts only after ready was seen.
    a_r5_sample_from_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_sample) |-> $past(ready));
    // R8: a timeout always lands in idle.
    a_r8_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> (state == ST_IDLE && !result_valid));
endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RB   = 16;
    localparam int HI   = 3;
    localparam int LO   = 3;
    localparam int PER  = HI + LO;
    localparam int SAMP = 4;
    localparam int FCD  = 2;
    localparam int CALP = 3;
    localparam int WL   = 300;
    localparam int CAL_LEN = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_req = 1'b0, cal_req = 1'b0;
    logic ready, result_valid, timeout_err, adc_sample, adc_clk, adc_cal;
    logic [RB-1:0] result_data;
    logic busy_m = 1'b0, busy_force = 1'b0, sclk_m = 1'b0, sdata_m = 1'b0;
    logic adc_busy;

    assign adc_busy = busy_m | busy_force;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq_ctrl #(
        .RES_BITS(RB), .CLK_HI_CYC(HI), .CLK_LO_CYC(LO), .SAMPLE_CYC(SAMP),
        .FIRST_DLY_CYC(FCD), .CAL_PULSE_CYC(CALP), .WAIT_LIMIT_CYC(WL)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .cal_req(cal_req),
        .ready(ready), .result_data(result_data), .result_valid(result_valid),
        .timeout_err(timeout_err), .adc_sample(adc_sample), .adc_clk(adc_clk),
        .adc_cal(adc_cal), .adc_busy(adc_busy), .adc_sclk(sclk_m), .adc_sdata(sdata_m)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Converter model
    logic [RB-1:0] model_word = '0;
    int  bitn = 0, cal_cnt = 0;
    bit  conv_act = 0, cal_act = 0, stuck_conv = 0, no_cal_resp = 0;

    always @(negedge adc_sample) if (rst_n) begin
        busy_m <= 1'b1; bitn = 0; conv_act = 1;
    end
    always @(negedge adc_cal) if (rst_n && !no_cal_resp) begin
        busy_m <= 1'b1; cal_act = 1; cal_cnt = 0;
    end
    always @(posedge adc_clk) if (rst_n) begin
        if (cal_act) begin
            cal_cnt++;
            if (cal_cnt == CAL_LEN) begin busy_m <= 1'b0; cal_act = 0; end
        end else if (conv_act) begin
            sclk_m <= 1'b0;
            if (bitn < RB) sdata_m <= model_word[RB-1-bitn];
            else begin
                if (!stuck_conv) busy_m <= 1'b0;
                conv_act = 0;
            end
        end
    end
    always @(negedge adc_clk) if (rst_n && conv_act && bitn < RB) begin
        sclk_m <= 1'b1; bitn++;
    end

    // Pin monitor
    int cyc = 0;
    int t_srise = 0, t_sfall = 0, t_crise = 0, t_calr = 0, t_calf = 0;
    int s_len = 0, gap = 0, rises = 0, per_bad = 0, hi_bad = 0, cal_len = 0;
    int samp_rises = 0, cal_rises = 0, valid_cnt = 0;
    logic p_s = 0, p_c = 0, p_cal = 0;

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (adc_sample && !p_s) begin t_srise = cyc; samp_rises++; end
        if (!adc_sample && p_s) begin s_len = cyc - t_srise; t_sfall = cyc; end
        if (adc_clk && !p_c) begin
            rises++;
            if (rises == 1) gap = cyc - t_sfall;
            else if (cyc - t_crise != PER) per_bad++;
            t_crise = cyc;
        end
        if (!adc_clk && p_c && (cyc - t_crise != HI)) hi_bad++;
        if (adc_cal && !p_cal) begin t_calr = cyc; cal_rises++; end
        if (!adc_cal && p_cal) begin cal_len = cyc - t_calr; t_calf = cyc; end
        if (result_valid) valid_cnt++;
        p_s = adc_sample; p_c = adc_clk; p_cal = adc_cal;
    end

    task automatic clr_mon();
        @(posedge clk);
        rises = 0; per_bad = 0; hi_bad = 0; samp_rises = 0;
        cal_rises = 0; valid_cnt = 0;
    endtask

    task automatic pulse_req(input bit cv, input bit cl);
        @(negedge clk); conv_req = cv; cal_req = cl;
        @(negedge clk); conv_req = 0; cal_req = 0;
    endtask

    task automatic wait_valid(output logic [RB-1:0] got, output bit ok);
        ok = 0; got = '0;
        for (int k = 0; k < 2000 && !ok; k++) begin
            @(negedge clk);
            if (result_valid) begin ok = 1; got = result_data; end
        end
    endtask

    task automatic do_conv(input logic [RB-1:0] w, input bit poke);
        logic [RB-1:0] got;
        bit ok;
        model_word = w;
        clr_mon();
        pulse_req(1, 0);
        repeat (3) @(negedge clk);
        chk("R5 ready low during conversion", ready, 0);
        if (poke) pulse_req(1, 1);
        wait_valid(got, ok);
        chk("R4 valid seen", ok, 1);
        chk("R4 result word", got, w);
        @(negedge clk);
        chk("R4 valid one cycle", result_valid, 0);
        chk("R2 sample width", s_len, SAMP);
        chk("R2 first clock gap", gap, FCD);
        chk("R3 pulse count", rises, RB + 1);
        chk("R3 period errors", per_bad, 0);
        chk("R3 high width errors", hi_bad, 0);
        repeat (10) @(negedge clk);
        chk("R5 single sample window", samp_rises, 1);
        chk("R5 no stray calibration", cal_rises, 0);
        chk("R5 ready after conversion", ready, 1);
    endtask

    initial begin
        logic [RB-1:0] w, got;
        bit ok;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", ready, 1);
        chk("R1 valid", result_valid, 0);
        chk("R1 err", timeout_err, 0);
        chk("R1 data", result_data, 0);
        chk("R1 strobes", {adc_sample, adc_clk, adc_cal}, 0);

        // Pattern sweep: walking ones, extremes, mixed values (R2 R3 R4)
        for (int i = 0; i < 24; i++) begin
            if (i < 16) w = 16'h1 << i;
            else if (i == 16) w = 16'h0000;
            else if (i == 17) w = 16'hFFFF;
            else w = 16'hA5A5 ^ 16'(i * 16'h3C3C);
            do_conv(w, i == 5);
        end

        // R5: request ignored while busy high in idle
        busy_force = 1'b1;
        repeat (4) @(negedge clk);
        chk("R5 ready low on busy", ready, 0);
        clr_mon();
        pulse_req(1, 0);
        repeat (20) @(negedge clk);
        chk("R5 busy blocks sample", samp_rises, 0);
        busy_force = 1'b0;
        repeat (4) @(negedge clk);
        chk("R5 ready after busy", ready, 1);

        // R6 + R7: simultaneous request, calibration wins and completes
        clr_mon();
        pulse_req(1, 1);
        for (int k = 0; k < 1000 && !(ready && cal_rises == 1 && !adc_cal && rises > 0); k++)
            @(negedge clk);
        repeat (10) @(negedge clk);
        chk("R6 calibration started", cal_rises, 1);
        chk("R6 conversion dropped", samp_rises, 0);
        chk("R7 cal strobe width", cal_len, CALP);
        chk("R7 cal clock pulses", rises, CAL_LEN);
        chk("R7 no valid on cal", valid_cnt, 0);
        chk("R7 ready after cal", ready, 1);
        chk("R7 clock stopped", adc_clk, 0);

        // R8: calibration with no busy response times out exactly
        no_cal_resp = 1;
        clr_mon();
        pulse_req(0, 1);
        @(negedge clk);
        while (adc_cal) @(negedge clk);
        for (int k = 0; k < 2000 && !ready; k++) @(negedge clk);
        chk("R8 cal timeout latency", cyc - t_calf, WL);
        chk("R8 err set on cal", timeout_err, 1);
        no_cal_resp = 0;

        // R8: conversion with stuck busy
        stuck_conv = 1;
        model_word = 16'h1234;
        clr_mon();
        pulse_req(1, 0);
        chk("R8 err cleared on accept", timeout_err, 0);
        for (int k = 0; k < 2000 && !timeout_err; k++) @(negedge clk);
        chk("R8 err set on conversion", timeout_err, 1);
        chk("R8 no valid on timeout", valid_cnt, 0);
        chk("R8 clock idle after timeout", adc_clk, 0);
        stuck_conv = 0;
        busy_m = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 ready after release", ready, 1);
        model_word = 16'h5AC3;
        pulse_req(1, 0);
        wait_valid(got, ok);
        chk("R8 recovery result", got, 16'h5AC3);
        chk("R8 err cleared", timeout_err, 0);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule